// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

This block is the control sequencer for a switched-capacitor waveform sampler with four data channels and one reference channel. The reference channel records the sampling window. While the block is idle, the write enable to every channel of the cell array stays high, so the sampling write path runs freely on the reference clock. When a trigger arrives, all write enables drop together, so every channel holds the samples of the same instant. In that same cycle the block sends one conversion-start pulse to all converters at once.

When the converters report completion, the block sends one readout-start pulse. In that same cycle it turns the write enables back on, so new samples can be taken while readout is still running. When readout reports completion, the block re-arms for the next trigger. A trigger that arrives while a capture is in progress is dropped. Each dropped trigger increments a saturating counter.

Top module: `acq_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, all write-enable bits are 1, the conversion-start and readout-start pulses are 0, busy is 0, and the dropped-trigger count is 0.
- R2: A trigger event (trigger high in a cycle after a cycle in which it was low) sampled while the block is idle makes, one cycle later, all write-enable bits 0 at once and a conversion-start pulse that is exactly one cycle long.
- R3: Busy is 1 from the cycle of the conversion-start pulse up to and including the cycle in which conversion-done is sampled high. It is 0 from the next cycle on.
- R4: The readout-start pulse is exactly one cycle long. It appears only in the cycle after conversion-done is sampled high while conversion is running.
- R5: In the cycle of the readout-start pulse, all write-enable bits are 1 again. They stay 1 while readout runs.
- R6: A trigger event that arrives while conversion or readout is running produces no conversion-start pulse and leaves the write enables unchanged. It increments the dropped-trigger count by one.
- R7: A trigger held high over several cycles counts as one event only. Holding it high neither starts a second capture nor counts a drop.
- R8: When readout-done is sampled high during readout, the block returns to idle. The next trigger event starts a new capture.
- R9: The dropped-trigger count saturates at its maximum value (255 with the default 8-bit width).
- R10: Conversion-done and readout-done have no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger; a low-to-high change is one event |
| conv_done_i | input | 1 | Conversion-complete strobe from the converters |
| read_done_i | input | 1 | Readout-complete strobe from the readout logic |
| wr_en_o | output | NUM_CH (5) | Write enable per channel; bit 4 is the reference channel |
| conv_start_o | output | 1 | One-cycle pulse that starts every conversion in parallel |
| read_start_o | output | 1 | One-cycle pulse that starts readout |
| busy_o | output | 1 | High while samples are frozen and conversion runs |
| drop_cnt_o | output | CNT_W (8) | Saturating count of dropped triggers |

## Verification
The hardest case to reach is the saturation of the dropped-trigger counter. It needs hundreds of separate trigger edges, all of them inside a single capture. The stimulus starts one capture and holds off conversion-done. It then toggles the trigger low and high more than 255 times, and the scoreboard tracks the expected count at every step. Held triggers, and completion strobes that arrive while the block is idle, are placed between the normal captures. Each of them is checked against outputs that must not move.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_WRITE = 2'd0,
    ST_CONV  = 2'd1,
    ST_READ  = 2'd2
  } acq_state_e;
endpackage

// File: rtl/acq_trig_edge.sv
module acq_trig_edge (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic evt_o
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig_i;
  end

  assign evt_o = trig_i & ~trig_q;
endmodule

// File: rtl/acq_drop_ctr.sv
module acq_drop_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                           cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig_evt_i,
  input  logic conv_done_i,
  input  logic read_done_i,
  output logic wr_o,
  output logic conv_start_o,
  output logic read_start_o,
  output logic busy_o,
  output logic drop_o
);
  acq_state_e state_q, state_d;
  logic accept, finish;
  logic wr_q, cs_q, rs_q, busy_q;

  assign accept = (state_q == ST_WRITE) && trig_evt_i;
  assign finish = (state_q == ST_CONV) && conv_done_i;
  assign drop_o = trig_evt_i && (state_q != ST_WRITE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WRITE: if (trig_evt_i)  state_d = ST_CONV;
      ST_CONV:  if (conv_done_i) state_d = ST_READ;
      ST_READ:  if (read_done_i) state_d = ST_WRITE;
      default:                   state_d = ST_WRITE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WRITE;
      wr_q    <= 1'b1;
      cs_q    <= 1'b0;
      rs_q    <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= (state_d != ST_CONV);
      cs_q    <= accept;
      rs_q    <= finish;
      busy_q  <= (state_d == ST_CONV);
    end
  end

  assign wr_o         = wr_q;
  assign conv_start_o = cs_q;
  assign read_start_o = rs_q;
  assign busy_o       = busy_q;
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter  int DATA_CH = 4,
  parameter  int REF_CH  = 1,
  parameter  int CNT_W   = 8,
  localparam int NUM_CH  = DATA_CH + REF_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              conv_done_i,
  input  logic              read_done_i,
  output logic [NUM_CH-1:0] wr_en_o,
  output logic              conv_start_o,
  output logic              read_start_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  logic trig_evt, wr_common, drop;

  acq_trig_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .trig_i(trig_i),
    .evt_o (trig_evt)
  );

  acq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .trig_evt_i  (trig_evt),
    .conv_done_i (conv_done_i),
    .read_done_i (read_done_i),
    .wr_o        (wr_common),
    .conv_start_o(conv_start_o),
    .read_start_o(read_start_o),
    .busy_o      (busy_o),
    .drop_o      (drop)
  );

  acq_drop_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .inc_i(drop),
    .cnt_o(drop_cnt_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
    assign wr_en_o[g] = wr_common;
  end
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              trig_i,
  input logic              conv_done_i,
  input logic              read_done_i,
  input logic [NUM_CH-1:0] wr_en_o,
  input logic              conv_start_o,
  input logic              read_start_o,
  input logic              busy_o,
  input logic [CNT_W-1:0]  drop_cnt_o
);
  // R2
  freeze_all_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> (wr_en_o == '0) && busy_o);
  // R2
  conv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);
  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> read_start_o);
  // R3
  busy_begin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> conv_start_o);
  // R4
  read_after_conv_chk: assert property (@(posedge clk) disable iff (rst)
    read_start_o |-> $past(conv_done_i) && $past(busy_o));
  // R4
  read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    read_start_o |=> !read_start_o);
  // R5
  rearm_write_chk: assert property (@(posedge clk) disable iff (rst)
    read_start_o |-> (wr_en_o == '1) && !busy_o);
  // R6
  no_start_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> !$past(busy_o));
  // R6
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + 1'b1));
  // R9
  drop_sat_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(drop_cnt_o) == '1) |-> (drop_cnt_o == '1));
endmodule

bind acq_sequencer acq_sequencer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_acq_sequencer.sv
module sim_acq_sequencer;
  localparam int NCH = 5;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0, cdone = 1'b0, rdone = 1'b0;
  logic [NCH-1:0] wr_en;
  logic cs, rs, busy;
  logic [CW-1:0] cnt;

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    int             at;
    logic [NCH-1:0] wr;
    logic           cs;
    logic           rs;
    logic           busy;
    logic [CW-1:0]  cnt;
    string          tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  acq_sequencer u0 (
    .clk(clk), .rst(rst), .trig_i(trig), .conv_done_i(cdone), .read_done_i(rdone),
    .wr_en_o(wr_en), .conv_start_o(cs), .read_start_o(rs), .busy_o(busy), .drop_cnt_o(cnt)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare at falling edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at == cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (wr_en !== e.wr || cs !== e.cs || rs !== e.rs || busy !== e.busy || cnt !== e.cnt) begin
        n_fail++;
        $display("FAIL %s: got wr=%b cs=%b rs=%b busy=%b cnt=%0d, exp wr=%b cs=%b rs=%b busy=%b cnt=%0d",
                 e.tag, wr_en, cs, rs, busy, cnt, e.wr, e.cs, e.rs, e.busy, e.cnt);
      end
    end
  end

  // driver: apply inputs just after a rising edge, expect outputs after the next one
  task automatic step(input logic t, input logic c, input logic r,
                      input logic w, input logic ecs, input logic ers,
                      input logic eb, input string tag);
    exp_t e;
    trig  = t;
    cdone = c;
    rdone = r;
    e.at   = cyc + 1;
    e.wr   = w ? '1 : '0;
    e.cs   = ecs;
    e.rs   = ers;
    e.busy = eb;
    e.cnt  = CW'(exp_cnt);
    e.tag  = tag;
    sb.push_back(e);
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if (wr_en !== '1 || cs !== 1'b0 || rs !== 1'b0 || busy !== 1'b0 || cnt !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: got wr=%b cs=%b rs=%b busy=%b cnt=%0d, exp wr=11111 cs=0 rs=0 busy=0 cnt=0",
               wr_en, cs, rs, busy, cnt);
    end
    @(posedge clk);
    #1;
    rst = 1'b0;
    step(0, 0, 0, 1, 0, 0, 0, "R1 first cycle out of reset");
    step(0, 1, 1, 1, 0, 0, 0, "R10 strobes ignored in idle");
    step(0, 0, 0, 1, 0, 0, 0, "R10 still idle");
    step(1, 0, 0, 0, 1, 0, 1, "R2 trigger freezes writes");
    step(1, 0, 0, 0, 0, 0, 1, "R7 held trigger not a new event");
    step(0, 0, 0, 0, 0, 0, 1, "R3 busy during conversion");
    exp_cnt = 1;
    step(1, 0, 0, 0, 0, 0, 1, "R6 trigger dropped in conversion");
    step(0, 1, 0, 1, 0, 1, 0, "R4 readout start after conv done");
    step(0, 0, 0, 1, 0, 0, 0, "R5 writes on during readout");
    exp_cnt = 2;
    step(1, 0, 0, 1, 0, 0, 0, "R6 trigger dropped in readout");
    step(0, 0, 1, 1, 0, 0, 0, "R8 readout done");
    step(1, 0, 0, 0, 1, 0, 1, "R8 rearmed trigger accepted");
    step(0, 1, 0, 1, 0, 1, 0, "R4 second readout start");
    step(0, 0, 1, 1, 0, 0, 0, "R8 second readout done");
    step(0, 0, 0, 1, 0, 0, 0, "R10 idle again");
    // saturation run inside one capture
    step(1, 0, 0, 0, 1, 0, 1, "R2 capture for saturation");
    step(0, 0, 0, 0, 0, 0, 1, "R3 busy holds");
    for (int i = 0; i < 260; i++) begin
      if (exp_cnt < 255) exp_cnt++;
      step(1, 0, 0, 0, 0, 0, 1, "R9 drop count climbs or saturates");
      step(0, 0, 0, 0, 0, 0, 1, "R9 count stable on low trigger");
    end
    step(0, 1, 0, 1, 0, 1, 0, "R4 readout after saturation");
    step(0, 0, 1, 1, 0, 0, 0, "R8 back to idle");
    step(0, 0, 0, 1, 0, 0, 0, "R9 count held at max");
    repeat (2) @(posedge clk);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      summary();
    end
  end
endmodule